// File: doc/BRIEF.md
# Time-Multiplexed Overrange Flag

This block reports overrange on a stereo sample path through a single active-low flag pin. Pulses on `ovr_left` or `ovr_right` mark the matching channel as overflowed. Both channel statuses then stay marked for a hold window that is counted in frames. The pin carries the two statuses in turn, following the frame clock `lrck`. The pin is modelled as a drive-low enable, `flag_pull_low`. A high value means the pin is pulled to 0, and a low value lets an external pull-up read 1.

All logic runs on a system clock `clk`. The serial bit clock reaches the block as `bclk_tick`, a one-cycle strobe at each bit-clock falling edge. `lrck` is sampled at that strobe and may change only in a strobe cycle. A frame is counted at each rising `lrck` edge.

The pin changes a fixed number of bit ticks after each `lrck` edge. The number depends on the serial format. The pin value for a channel therefore sits stable across the next `lrck` edge, where a receiver can latch it. Such a receiver is built in to demultiplex the pin for checking, and it drives `seen_left` and `seen_right`.

The pin sequencer is a state machine with three states:
- WATCH waits for an `lrck` edge.
- LAG spends one extra bit tick and is used only in I2S format.
- ARM loads the pin on the next bit tick.

Its transitions are:
- WATCH→LAG on an edge in I2S format.
- WATCH→ARM on an edge in left-justified format.
- LAG→ARM on a bit tick.
- ARM→WATCH on a bit tick, which updates the pin.

Top module: `ovr_flag_mux`

## Requirements
- R1: While `rst_n` is low, `flag_pull_low`, `seen_left` and `seen_right` are 0, and the hold window and both channel statuses are cleared.
- R2: An `ovr_left` or `ovr_right` pulse marks that channel as overflowed from the next clock on. At the next pin update that shows the channel, `flag_pull_low` is 1.
- R3: The statuses stay marked until LIMIT rising `lrck` edges have passed since the last overrange pulse, and then both clear. LIMIT depends on `speed`:
  - `speed` = 0 gives BASE_FRAMES.
  - `speed` = 1 gives 2×BASE_FRAMES.
  - `speed` = 2 gives 4×BASE_FRAMES.
  - `speed` = 3 is treated as 0.
- R4: One hold window is shared. A pulse on either channel reloads it, and the expiry clears both channels in the same cycle.
- R5: With `fmt_i2s` = 0 (left-justified), the pin is loaded at the first bit tick after each `lrck` edge. After a falling edge it shows the right status, and after a rising edge it shows the left status.
- R6: With `fmt_i2s` = 1 (I2S), the pin is loaded at the second bit tick after each `lrck` edge. After a rising edge it shows the right status, and after a falling edge it shows the left status.
- R7: At each `lrck` edge tick, the receiver latches the current `flag_pull_low` into one output:
  - With `fmt_i2s` = 0, a rising edge loads `seen_right` and a falling edge loads `seen_left`.
  - With `fmt_i2s` = 1, the two edges are swapped.
- R8: `flag_pull_low` changes only in the clock cycle that follows a `bclk_tick` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_tick | input | 1 | One-cycle strobe at each bit-clock falling edge |
| lrck | input | 1 | Frame clock level, changes only in a `bclk_tick` cycle |
| ovr_left | input | 1 | Left-channel overrange pulse |
| ovr_right | input | 1 | Right-channel overrange pulse |
| fmt_i2s | input | 1 | 1 = I2S format, 0 = left-justified |
| speed | input | 2 | 0 single, 1 double, 2 quad, 3 treated as single |
| flag_pull_low | output | 1 | Pin drive-low enable (pin reads 0 when 1) |
| seen_left | output | 1 | Receiver's demultiplexed left overflow |
| seen_right | output | 1 | Receiver's demultiplexed right overflow |

## Verification
The bench builds the block with BASE_FRAMES = 2, so the hold window is 2, 4 or 8 frames. Expiry, reload by the other channel, and every speed setting therefore fit in a dozen frames each. This brings the exact frame in which both statuses clear within reach, in both formats. It also covers the reserved speed code and a second pulse that lands inside a running window.

// File: rtl/ovf_pkg.sv
package ovf_pkg;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'd0,
        SPD_DOUBLE = 2'd1,
        SPD_QUAD   = 2'd2,
        SPD_RSVD   = 2'd3
    } speed_e;

    typedef enum logic [1:0] {
        MX_WATCH = 2'd0,
        MX_LAG   = 2'd1,
        MX_ARM   = 2'd2
    } mux_state_e;

    // scale of the hold window per speed setting (as a left shift)
    function automatic logic [1:0] speed_shift(input logic [1:0] spd);
        unique case (speed_e'(spd))
            SPD_DOUBLE: speed_shift = 2'd1;
            SPD_QUAD:   speed_shift = 2'd2;
            default:    speed_shift = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/ovf_hold_timer.sv
module ovf_hold_timer #(
    parameter int BASE_FRAMES = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovr_left,
    input  logic       ovr_right,
    input  logic       frame_tick,
    input  logic [1:0] speed,
    output logic       stat_l,
    output logic       stat_r
);
    import ovf_pkg::*;

    localparam int CNT_W = $clog2(BASE_FRAMES * 4 + 1);

    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'(BASE_FRAMES) << speed_shift(speed);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
            stat_l <= 1'b0;
            stat_r <= 1'b0;
        end else if (ovr_left || ovr_right) begin
            remain <= limit;
            if (ovr_left)  stat_l <= 1'b1;
            if (ovr_right) stat_r <= 1'b1;
        end else if (frame_tick && remain != '0) begin
            remain <= remain - 1'b1;
            if (remain == CNT_W'(1)) begin
                stat_l <= 1'b0;
                stat_r <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ovf_pin_sequencer.sv
module ovf_pin_sequencer (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_tick,
    input  logic lr_edge,
    input  logic lrck,
    input  logic fmt_i2s,
    input  logic stat_l,
    input  logic stat_r,
    output logic flag_pull_low
);
    import ovf_pkg::*;

    mux_state_e st, nxt;
    logic       pick_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= MX_WATCH;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            MX_WATCH: if (lr_edge)   nxt = fmt_i2s ? MX_LAG : MX_ARM;
            MX_LAG:   if (bclk_tick) nxt = MX_ARM;
            MX_ARM:   if (bclk_tick) nxt = MX_WATCH;
            default:                 nxt = MX_WATCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pick_r        <= 1'b0;
            flag_pull_low <= 1'b0;
        end else begin
            if (st == MX_WATCH && lr_edge)
                pick_r <= (lrck == fmt_i2s);
            if (st == MX_ARM && bclk_tick)
                flag_pull_low <= pick_r ? stat_r : stat_l;
        end
    end
endmodule

// File: rtl/ovf_flag_receiver.sv
module ovf_flag_receiver (
    input  logic clk,
    input  logic rst_n,
    input  logic lr_edge,
    input  logic lrck,
    input  logic fmt_i2s,
    input  logic pin_low,
    output logic seen_left,
    output logic seen_right
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_left  <= 1'b0;
            seen_right <= 1'b0;
        end else if (lr_edge) begin
            if (lrck ^ fmt_i2s) seen_right <= pin_low;
            else                seen_left  <= pin_low;
        end
    end
endmodule

// File: rtl/ovr_flag_mux.sv
module ovr_flag_mux #(
    parameter int BASE_FRAMES = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bclk_tick,
    input  logic       lrck,
    input  logic       ovr_left,
    input  logic       ovr_right,
    input  logic       fmt_i2s,
    input  logic [1:0] speed,
    output logic       flag_pull_low,
    output logic       seen_left,
    output logic       seen_right
);
    logic lrck_q;
    logic lr_edge;
    logic lrck_rise;
    logic stat_l;
    logic stat_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         lrck_q <= 1'b0;
        else if (bclk_tick) lrck_q <= lrck;
    end

    assign lr_edge   = bclk_tick && (lrck != lrck_q);
    assign lrck_rise = lr_edge && lrck;

    ovf_hold_timer #(.BASE_FRAMES(BASE_FRAMES)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .ovr_left   (ovr_left),
        .ovr_right  (ovr_right),
        .frame_tick (lrck_rise),
        .speed      (speed),
        .stat_l     (stat_l),
        .stat_r     (stat_r)
    );

    ovf_pin_sequencer u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .bclk_tick     (bclk_tick),
        .lr_edge       (lr_edge),
        .lrck          (lrck),
        .fmt_i2s       (fmt_i2s),
        .stat_l        (stat_l),
        .stat_r        (stat_r),
        .flag_pull_low (flag_pull_low)
    );

    ovf_flag_receiver u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .lr_edge    (lr_edge),
        .lrck       (lrck),
        .fmt_i2s    (fmt_i2s),
        .pin_low    (flag_pull_low),
        .seen_left  (seen_left),
        .seen_right (seen_right)
    );
endmodule

// File: rtl/ovf_checker.sv
module ovf_checker (
    input logic clk,
    input logic rst_n,
    input logic bclk_tick,
    input logic ovr_left,
    input logic ovr_right,
    input logic lrck_rise,
    input logic stat_l,
    input logic stat_r,
    input logic flag_pull_low
);
    // R2
    mark_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_left |=> stat_l);

    // R2
    mark_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_right |=> stat_r);

    // R3
    hold_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_l && !lrck_rise) |=> stat_l);

    // R3
    hold_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_r && !lrck_rise) |=> stat_r);

    // R4
    shared_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(stat_l) && $past(stat_r)) |-> !stat_r);

    // R8
    pin_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flag_pull_low) |-> $past(bclk_tick));
endmodule

bind ovr_flag_mux ovf_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bclk_tick     (bclk_tick),
    .ovr_left      (ovr_left),
    .ovr_right     (ovr_right),
    .lrck_rise     (lrck_rise),
    .stat_l        (stat_l),
    .stat_r        (stat_r),
    .flag_pull_low (flag_pull_low)
);

// File: tb/tb_ovr_flag_mux.sv
module tb_ovr_flag_mux;
    localparam int BASE = 2;

    typedef struct packed {
        logic       fmt;
        logic [1:0] spd;
        logic [1:0] inj1;
        logic [3:0] gap;
        logic [1:0] inj2;
        logic [4:0] nfr;
        logic [3:0] req;
    } vec_t;

    // inj: bit0 = left, bit1 = right; gap = frame of second pulse (0 = none)
    localparam vec_t VECS [8] = '{
        '{1'b0, 2'd0, 2'd2, 4'd0, 2'd0, 5'd5,  4'd5},
        '{1'b0, 2'd0, 2'd1, 4'd0, 2'd0, 5'd5,  4'd2},
        '{1'b1, 2'd0, 2'd2, 4'd0, 2'd0, 5'd5,  4'd6},
        '{1'b1, 2'd1, 2'd1, 4'd0, 2'd0, 5'd7,  4'd3},
        '{1'b0, 2'd2, 2'd3, 4'd0, 2'd0, 5'd12, 4'd3},
        '{1'b0, 2'd0, 2'd1, 4'd1, 2'd2, 5'd6,  4'd4},
        '{1'b1, 2'd3, 2'd2, 4'd0, 2'd0, 5'd5,  4'd3},
        '{1'b1, 2'd1, 2'd2, 4'd3, 2'd1, 5'd9,  4'd4}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk_tick = 1'b0;
    logic lrck = 1'b0;
    logic ovr_left = 1'b0;
    logic ovr_right = 1'b0;
    logic fmt_i2s = 1'b0;
    logic [1:0] speed = 2'd0;
    logic flag_pull_low, seen_left, seen_right;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    // reference model state
    logic m_l, m_r, m_flag, m_sl, m_sr, m_sel, m_prev;
    int   m_cnt, m_pend, m_limit;
    string cur_tag;

    always #2.5 clk = ~clk;

    ovr_flag_mux #(.BASE_FRAMES(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .bclk_tick(bclk_tick), .lrck(lrck),
        .ovr_left(ovr_left), .ovr_right(ovr_right), .fmt_i2s(fmt_i2s),
        .speed(speed), .flag_pull_low(flag_pull_low),
        .seen_left(seen_left), .seen_right(seen_right)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_l = 0; m_r = 0; m_flag = 0; m_sl = 0; m_sr = 0;
        m_sel = 0; m_prev = 0; m_cnt = 0; m_pend = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic inject(input logic [1:0] which);
        if (which == 2'd0) return;
        @(negedge clk);
        ovr_left = which[0];
        ovr_right = which[1];
        @(negedge clk);
        ovr_left = 1'b0;
        ovr_right = 1'b0;
        if (which[0]) m_l = 1;
        if (which[1]) m_r = 1;
        m_cnt = m_limit;
    endtask

    task automatic bit_tick(input logic lv);
        logic held;
        logic edge_now;
        edge_now = (lv != m_prev);
        @(negedge clk);
        lrck = lv;
        bclk_tick = 1'b1;
        @(negedge clk);
        bclk_tick = 1'b0;
        // model the tick
        if (edge_now) begin
            if (lv ^ fmt_i2s) m_sr = m_flag;
            else              m_sl = m_flag;
            m_pend = fmt_i2s ? 2 : 1;
            m_sel  = (lv == fmt_i2s);
            if (lv && m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_l = 0;
                    m_r = 0;
                end
            end
        end else if (m_pend > 0) begin
            m_pend--;
            if (m_pend == 0) m_flag = m_sel ? m_r : m_l;
        end
        m_prev = lv;
        check(cur_tag, flag_pull_low, m_flag);
        check("R7", seen_left, m_sl);
        check("R7", seen_right, m_sr);
        held = flag_pull_low;
        repeat (2) @(negedge clk);
        check("R8", flag_pull_low, held);
    endtask

    function automatic string req_tag(input logic [3:0] r);
        case (r)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic int limit_of(input logic [1:0] s);
        case (s)
            2'd1:    return BASE * 2;
            2'd2:    return BASE * 4;
            default: return BASE;
        endcase
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual hung expected done");
                $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", flag_pull_low, 1'b0);
        check("R1", seen_left, 1'b0);
        check("R1", seen_right, 1'b0);
        rst_n = 1'b1;

        foreach (VECS[i]) begin
            fmt_i2s = VECS[i].fmt;
            speed   = VECS[i].spd;
            m_limit = limit_of(VECS[i].spd);
            cur_tag = req_tag(VECS[i].req);
            lrck    = 1'b0;
            do_reset();
            for (int fr = 0; fr < int'(VECS[i].nfr); fr++) begin
                for (int b = 0; b < 64; b++) begin
                    if (b == 10 && fr == 0) inject(VECS[i].inj1);
                    if (b == 10 && VECS[i].gap != 0 && fr == int'(VECS[i].gap))
                        inject(VECS[i].inj2);
                    bit_tick(b >= 32);
                end
            end
        end

        // R1: reset mid-run with flag active clears everything
        fmt_i2s = 1'b0;
        speed   = 2'd0;
        m_limit = BASE;
        cur_tag = "R5";
        lrck    = 1'b0;
        do_reset();
        inject(2'd3);
        for (int b = 0; b < 64; b++) bit_tick(b >= 32);
        check("R2", flag_pull_low, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", flag_pull_low, 1'b0);
        check("R1", seen_left, 1'b0);
        check("R1", seen_right, 1'b0);
        // statuses cleared by reset: no flag after the next update point
        rst_n = 1'b1;
        lrck  = 1'b0;
        model_reset();
        for (int b = 0; b < 64; b++) bit_tick(b >= 32);
        for (int b = 0; b < 2; b++) bit_tick(1'b0);
        check("R1", flag_pull_low, 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule